// File: doc/BRIEF.md
# Fat-Tree Packet Switch Node

This block is one switching node of a butterfly fat-tree network that routes single-word packets at run time. It has three bidirectional packet ports: two child ports that lead down into the node's subtree and one parent port that leads up toward the root. Each packet word carries a destination leaf address in its upper bits and a payload in its lower bits. Every input port owns a small FIFO queue, so a sender is only stalled when its own queue is full.

A node sits at a fixed tree level and owns a fixed address prefix. When a packet reaches the head of its queue, the node compares the prefix bits of the destination with its own prefix. A match means the leaf lies below this node, and one address bit, selected by the level, picks the left or right child. Any other packet is sent toward the parent. At each output, a merge arbiter picks among the queues whose head packet wants that output. The queue holding more packets wins. Each output is a register with a valid/ready handshake.

Top module: `ftSwitch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `outValid` bit is 0 and every `inReady` bit is 1.
- R2: A packet word is `ADDR_W + PAY_W` bits wide. The destination address occupies the upper `ADDR_W` bits and the payload the lower `PAY_W` bits. The whole word leaves the switch unchanged.
- R3: If destination bits `[ADDR_W-1:LEVEL+1]` equal `NODE_PREFIX`, the packet leaves on child port `addr[LEVEL]` (0 selects port 0, 1 selects port 1). At the root level every address counts as a match.
- R4: Any packet that does not match goes to the parent port, which is port index 2, whichever port it arrived on.
- R5: Suppose a packet is accepted at rising edge k into an empty queue, and its output register is empty with ready high. The packet is then visible on its output after rising edge k+1.
- R6: When several queue heads want the same free output, the queue with the larger occupancy is granted.
- R7: When the contending queues have equal occupancy, the lowest port index is granted.
- R8: A queue holding `DEPTH` packets drives its `inReady` low. A word offered while ready is low is not taken. No accepted packet is lost, and packets from one input to one output keep their order.
- R9: While `outValid` is high and `outReady` is low, the output keeps `outValid` high and `outData` unchanged.
- R10: Packets headed for different outputs do not block each other and can all advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 3 | Per-port packet offered (bit 0 child0, bit 1 child1, bit 2 parent) |
| inData | input | 3*(ADDR_W+PAY_W) | Per-port packet words, port p in slice p |
| inReady | output | 3 | Per-port queue can accept a packet |
| outValid | output | 3 | Per-port output register holds a packet |
| outData | output | 3*(ADDR_W+PAY_W) | Per-port outgoing packet words |
| outReady | input | 3 | Per-port downstream accepts the packet |

## Verification
Within a single edge, an output register can hand its packet downstream and also load the next winner from the arbiter, while the winning queue gives up its head. The bench provokes this case in a fixed way. It holds the parent output stalled while one child queue fills to one entry and the other to three. It then releases ready and samples the output on every cycle. The departure order must match an order derived from the queue counts, with ties going to the lower index. A dropped, duplicated or misordered word shows up directly in that sequence.

// File: rtl/fatTreePkg.sv
package fatTreePkg;

  localparam int NUM_PORTS = 3;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    PORT_CHILD0 = 2'd0,
    PORT_CHILD1 = 2'd1,
    PORT_PARENT = 2'd2
  } portId_t;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [NUM_PORTS-1:0]            popQ;
    logic [NUM_PORTS-1:0]            loadOut;
    logic [NUM_PORTS-1:0][SEL_W-1:0] selIn;
  } ctrlStrobe_t;

endpackage

// File: rtl/ftQueue.sv
module ftQueue #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = pushEn && !full;
  assign doPop    = popEn && !empty;
  assign headData = store[rdPtr];
  assign fill     = count;

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ftDatapath.sv
module ftDatapath
  import fatTreePkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PAY_W  = 8,
  parameter int DEPTH  = 4,
  localparam int PKT_W = ADDR_W + PAY_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PORTS-1:0]           inValid,
  input  logic [NUM_PORTS*PKT_W-1:0]     inData,
  output logic [NUM_PORTS-1:0]           inReady,
  input  ctrlStrobe_t                    strobe,
  output logic [NUM_PORTS*ADDR_W-1:0]    destFlat,
  output logic [NUM_PORTS*CNT_W-1:0]     fillFlat,
  output logic [NUM_PORTS-1:0]           emptyVec,
  output logic [NUM_PORTS-1:0]           outValid,
  output logic [NUM_PORTS*PKT_W-1:0]     outData,
  input  logic [NUM_PORTS-1:0]           outReady
);

  logic [PKT_W-1:0] headArr [NUM_PORTS];
  logic [NUM_PORTS-1:0] fullVec;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_queue
    ftQueue #(.WIDTH(PKT_W), .DEPTH(DEPTH)) u_queue (
      .clk      (clk),
      .rstN     (rstN),
      .pushEn   (inValid[i]),
      .pushData (inData[i*PKT_W +: PKT_W]),
      .popEn    (strobe.popQ[i]),
      .headData (headArr[i]),
      .fill     (fillFlat[i*CNT_W +: CNT_W]),
      .full     (fullVec[i]),
      .empty    (emptyVec[i])
    );
    assign inReady[i]                   = !fullVec[i];
    assign destFlat[i*ADDR_W +: ADDR_W] = headArr[i][PKT_W-1 -: ADDR_W];
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [PKT_W-1:0] picked;
    logic             validReg;
    logic [PKT_W-1:0] dataReg;

    always_comb begin
      unique case (strobe.selIn[o])
        PORT_CHILD1: picked = headArr[1];
        PORT_PARENT: picked = headArr[2];
        default:     picked = headArr[0];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validReg <= 1'b0;
        dataReg  <= '0;
      end else if (strobe.loadOut[o]) begin
        validReg <= 1'b1;
        dataReg  <= picked;
      end else if (outReady[o]) begin
        validReg <= 1'b0;
      end
    end

    assign outValid[o]                = validReg;
    assign outData[o*PKT_W +: PKT_W]  = dataReg;
  end

endmodule

// File: rtl/ftControl.sv
module ftControl
  import fatTreePkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LEVEL       = 1,
  parameter int NODE_PREFIX = 1,
  parameter int DEPTH       = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic [NUM_PORTS*ADDR_W-1:0] destFlat,
  input  logic [NUM_PORTS*CNT_W-1:0]  fillFlat,
  input  logic [NUM_PORTS-1:0]        emptyVec,
  input  logic [NUM_PORTS-1:0]        outValid,
  input  logic [NUM_PORTS-1:0]        outReady,
  output ctrlStrobe_t                 strobe
);

  localparam logic [ADDR_W-1:0] PREFIX_V = ADDR_W'(NODE_PREFIX);

  logic [SEL_W-1:0]     target  [NUM_PORTS];
  logic [NUM_PORTS-1:0] reqMat  [NUM_PORTS];
  logic [NUM_PORTS-1:0] canLoad;

  // Split: one address bit per level, prefix match decides up or down.
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_split
    logic [ADDR_W-1:0] dest;
    logic              inSub;
    assign dest  = destFlat[i*ADDR_W +: ADDR_W];
    if (LEVEL >= ADDR_W - 1) begin : g_root
      assign inSub = 1'b1;
    end else begin : g_inner
      assign inSub = ((dest >> (LEVEL + 1)) == PREFIX_V);
    end
    assign target[i] = inSub ? (dest[LEVEL] ? PORT_CHILD1 : PORT_CHILD0) : PORT_PARENT;
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_req
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_bit
      assign reqMat[o][i] = !emptyVec[i] && (target[i] == SEL_W'(o));
    end
    assign canLoad[o] = !outValid[o] || outReady[o];
  end

  // Merge: fullest queue wins, strict compare keeps the lower index on ties.
  always_comb begin
    strobe = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      logic             found;
      logic [CNT_W-1:0] bestFill;
      logic [SEL_W-1:0] bestIdx;
      found    = 1'b0;
      bestFill = '0;
      bestIdx  = '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (reqMat[o][i] && (!found || fillFlat[i*CNT_W +: CNT_W] > bestFill)) begin
          found    = 1'b1;
          bestFill = fillFlat[i*CNT_W +: CNT_W];
          bestIdx  = SEL_W'(i);
        end
      end
      strobe.selIn[o] = bestIdx;
      if (found && canLoad[o]) begin
        strobe.loadOut[o] = 1'b1;
        for (int i = 0; i < NUM_PORTS; i++) begin
          if (bestIdx == SEL_W'(i)) strobe.popQ[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ftSwitch.sv
module ftSwitch
  import fatTreePkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PAY_W       = 8,
  parameter int LEVEL       = 1,
  parameter int NODE_PREFIX = 1,
  parameter int DEPTH       = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_PORTS-1:0]                  inValid,
  input  logic [NUM_PORTS*(ADDR_W+PAY_W)-1:0]   inData,
  output logic [NUM_PORTS-1:0]                  inReady,
  output logic [NUM_PORTS-1:0]                  outValid,
  output logic [NUM_PORTS*(ADDR_W+PAY_W)-1:0]   outData,
  input  logic [NUM_PORTS-1:0]                  outReady
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrobe_t                 strobe;
  logic [NUM_PORTS*ADDR_W-1:0] destFlat;
  logic [NUM_PORTS*CNT_W-1:0]  fillFlat;
  logic [NUM_PORTS-1:0]        emptyVec;

  ftDatapath #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .DEPTH(DEPTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inReady  (inReady),
    .strobe   (strobe),
    .destFlat (destFlat),
    .fillFlat (fillFlat),
    .emptyVec (emptyVec),
    .outValid (outValid),
    .outData  (outData),
    .outReady (outReady)
  );

  ftControl #(.ADDR_W(ADDR_W), .LEVEL(LEVEL), .NODE_PREFIX(NODE_PREFIX), .DEPTH(DEPTH)) u_control (
    .destFlat (destFlat),
    .fillFlat (fillFlat),
    .emptyVec (emptyVec),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

endmodule

// File: rtl/ftSwitchChecker.sv
module ftSwitchChecker
  import fatTreePkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PAY_W       = 8,
  parameter int LEVEL       = 1,
  parameter int NODE_PREFIX = 1,
  parameter int DEPTH       = 4,
  localparam int PKT_W      = ADDR_W + PAY_W,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_PORTS-1:0]         inReady,
  input logic [NUM_PORTS-1:0]         outValid,
  input logic [NUM_PORTS-1:0]         outReady,
  input logic [NUM_PORTS*PKT_W-1:0]   outData,
  input logic [NUM_PORTS*CNT_W-1:0]   fillFlat
);

  function automatic int expectPort(input logic [ADDR_W-1:0] a);
    if (LEVEL >= ADDR_W - 1) return int'(a[LEVEL]);
    if ((a >> (LEVEL + 1)) == ADDR_W'(NODE_PREFIX)) return int'(a[LEVEL]);
    return 2;
  endfunction

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_outChk
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outData[o*PKT_W +: PKT_W]));

    // R3 and R4: whatever leaves this port was addressed to it.
    assert_route_R3: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] |-> expectPort(outData[o*PKT_W + PAY_W +: ADDR_W]) == o);
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_inChk
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
      fillFlat[i*CNT_W +: CNT_W] <= CNT_W'(DEPTH));

    assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
      fillFlat[i*CNT_W +: CNT_W] == CNT_W'(DEPTH) |-> !inReady[i]);
  end

endmodule

bind ftSwitch ftSwitchChecker #(
  .ADDR_W(ADDR_W), .PAY_W(PAY_W), .LEVEL(LEVEL), .NODE_PREFIX(NODE_PREFIX), .DEPTH(DEPTH)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .fillFlat (fillFlat)
);

// File: tb/ftSwitch_tb.sv
module ftSwitch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int PAY_W  = 8;
  localparam int LEVEL  = 1;
  localparam int PREFIX = 1;
  localparam int DEPTH  = 4;
  localparam int PKT_W  = ADDR_W + PAY_W;
  localparam int NP     = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NP-1:0]      inValid = '0;
  logic [NP*PKT_W-1:0] inData = '0;
  logic [NP-1:0]      inReady;
  logic [NP-1:0]      outValid;
  logic [NP*PKT_W-1:0] outData;
  logic [NP-1:0]      outReady = '1;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftSwitch #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .LEVEL(LEVEL), .NODE_PREFIX(PREFIX), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expPort(input int a);
    if ((a >> (LEVEL + 1)) == PREFIX) return (a >> LEVEL) & 1;
    return 2;
  endfunction

  function automatic logic [PKT_W-1:0] mk(input int a, input int p);
    return {ADDR_W'(a), PAY_W'(p)};
  endfunction

  function automatic logic [PKT_W-1:0] outWord(input int o);
    return outData[o*PKT_W +: PKT_W];
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    check(outValid == 3'b000, "R1 outValid in reset", 32'(outValid), 0);
    check(inReady == 3'b111, "R1 inReady in reset", 32'(inReady), 32'h7);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 3'b000 && inReady == 3'b111, "R1 after reset",
          32'({outValid, inReady}), 32'h07);

    // R2 R3 R4 R5: sweep every address from every input port
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < 16; a++) begin
        int e;
        logic [PKT_W-1:0] w;
        e = expPort(a);
        w = mk(a, p * 16 + a + 1);
        @(negedge clk);
        inValid[p] = 1'b1;
        inData[p*PKT_W +: PKT_W] = w;
        @(negedge clk);
        inValid[p] = 1'b0;
        @(negedge clk);
        check(outValid == 3'(1 << e) && outWord(e) == w,
              (e == 2) ? "R4 R5 upward route" : "R3 R5 downward route",
              32'({outValid, outWord(e)}), 32'({3'(1 << e), w}));
      end
    end

    // R6 R7: occupancy arbitration on the parent output
    @(negedge clk);
    outReady = 3'b011;
    inValid[0] = 1; inData[0 +: PKT_W] = mk(0, 8'hA0);
    @(negedge clk);
    inValid[0] = 1; inData[0 +: PKT_W] = mk(1, 8'hA1);
    inValid[1] = 1; inData[PKT_W +: PKT_W] = mk(2, 8'hB0);
    @(negedge clk);
    inValid[0] = 0;
    inData[PKT_W +: PKT_W] = mk(3, 8'hB1);
    @(negedge clk);
    inData[PKT_W +: PKT_W] = mk(8, 8'hB2);
    @(negedge clk);
    inValid[1] = 0;
    @(negedge clk);
    check(outValid[2] && outWord(2) == mk(0, 8'hA0), "R9 held while stalled",
          32'(outWord(2)), 32'(mk(0, 8'hA0)));
    outReady = 3'b111;
    @(negedge clk);
    check(outWord(2) == mk(2, 8'hB0), "R6 fuller queue first", 32'(outWord(2)), 32'(mk(2, 8'hB0)));
    @(negedge clk);
    check(outWord(2) == mk(3, 8'hB1), "R6 fuller queue again", 32'(outWord(2)), 32'(mk(3, 8'hB1)));
    @(negedge clk);
    check(outWord(2) == mk(1, 8'hA1), "R7 tie to lower index", 32'(outWord(2)), 32'(mk(1, 8'hA1)));
    @(negedge clk);
    check(outValid[2] && outWord(2) == mk(8, 8'hB2), "R6 last packet", 32'(outWord(2)), 32'(mk(8, 8'hB2)));
    @(negedge clk);
    check(outValid == 3'b000, "R8 no duplicate", 32'(outValid), 0);

    // R8: fill a queue, offer while full, then drain in order
    begin
      int accepted;
      accepted = 0;
      outReady = 3'b011;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (inReady[0]) begin
          inValid[0] = 1;
          inData[0 +: PKT_W] = mk(0, 16 + accepted);
          accepted++;
        end else begin
          inValid[0] = 0;
        end
      end
      check(accepted == DEPTH + 1, "R8 accepted count", 32'(accepted), 32'(DEPTH + 1));
      check(inReady[0] == 1'b0, "R8 ready low when full", 32'(inReady[0]), 0);
      inValid[0] = 1;
      inData[0 +: PKT_W] = mk(0, 8'hEE);
      @(negedge clk);
      @(negedge clk);
      inValid[0] = 0;
      check(outWord(2) == mk(0, 16), "R9 stable under stall", 32'(outWord(2)), 32'(mk(0, 16)));
      outReady = 3'b111;
      for (int k = 1; k <= DEPTH; k++) begin
        @(negedge clk);
        check(outValid[2] && outWord(2) == mk(0, 16 + k), "R8 drain order",
              32'(outWord(2)), 32'(mk(0, 16 + k)));
      end
      @(negedge clk);
      check(outValid == 3'b000, "R8 offered word while full not taken", 32'(outValid), 0);
    end

    // R10: three packets to three outputs move together
    @(negedge clk);
    inValid = 3'b111;
    inData[0 +: PKT_W]       = mk(6, 8'h11);
    inData[PKT_W +: PKT_W]   = mk(4, 8'h22);
    inData[2*PKT_W +: PKT_W] = mk(9, 8'h33);
    @(negedge clk);
    inValid = 3'b000;
    @(negedge clk);
    check(outValid == 3'b111, "R10 all outputs valid", 32'(outValid), 32'h7);
    check(outWord(0) == mk(4, 8'h22) && outWord(1) == mk(6, 8'h11) && outWord(2) == mk(9, 8'h33),
          "R10 parallel data", 32'(outWord(0)), 32'(mk(4, 8'h22)));

    @(negedge clk);
    finish();
  end

endmodule